// File: doc/BRIEF.md
# Branch and Call Target Unit

This unit works out where control flow goes next for a 16-bit instruction word. It takes the instruction, the already incremented program counter, the value read from the base register the instruction names, and the current three-bit condition code. For a conditional branch it tests the instruction's condition mask against the condition code. For a register jump it selects the base value. For a subroutine call it picks either a PC-relative target or the base value, and it also produces the return address to be written into R7. Any other opcode lets the incremented PC through unchanged. The register file write and the instruction fetch belong to other blocks.

Each request and each result moves over a valid/ready handshake. A request is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. With `REG_OUT=1`, which is the default, the result is registered and shows up one cycle after acceptance. While a result is stalled by a low `out_ready`, it holds steady and `in_ready` stays low. When the stage is empty, `in_ready` is high regardless of `out_ready`. With `REG_OUT=0` the unit is purely combinational, and `in_ready` follows `out_ready`.

Top module: `branch_target_unit`

## Requirements
- R1: When reset is released, `out_valid` is 0 and `in_ready` is 1.
- R2: For opcode 0x0 (bits 15:12), where bits 11:9 are the N, Z, P mask and the condition code bits are N=bit2, Z=bit1, P=bit0, a non-zero AND of the mask with the condition code gives `out_taken`=1 and `out_next_pc` = PC + sign-extended bits 8:0.
- R3: For opcode 0x0 with a zero AND, which includes a mask of 000, the result is `out_taken`=0 and `out_next_pc` = PC.
- R4: Opcode 0xC gives `out_taken`=1 and `out_next_pc` = base value, with `out_link_we`=0.
- R5: Opcode 0x4 with bit 11 = 1 gives `out_taken`=1, `out_next_pc` = PC + sign-extended bits 10:0, `out_link_we`=1 and `out_link_val` = PC.
- R6: Opcode 0x4 with bit 11 = 0 gives `out_next_pc` = base value and `out_link_val` = PC. This holds even when the base field (bits 8:6) is 7, so a call through R7 goes to the old R7 value.
- R7: Every other opcode gives `out_next_pc` = PC, `out_taken`=0, `out_link_we`=0 and `out_link_val`=0. Any non-call result has `out_link_val`=0.
- R8: While `out_valid`=1 and `out_ready`=0, every output field holds steady and `in_ready`=0.
- R9: While `out_valid`=0, `in_ready`=1, so the empty stage accepts a request without a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_instr | input | 16 | Instruction word |
| in_pc_inc | input | XLEN | Incremented program counter |
| in_base | input | XLEN | Value of the register named by bits 8:6 |
| in_cc | input | 3 | Condition code {N,Z,P} |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed when high with out_valid |
| out_next_pc | output | XLEN | Next program counter |
| out_taken | output | 1 | Control flow leaves the sequential path |
| out_link_we | output | 1 | Write out_link_val into R7 |
| out_link_val | output | XLEN | Return address for a call |

## Verification
The hardest case to reach from the ports is a register call through R7. Here the base input stands for the old R7 content while the link value is the new return address, so the two must differ for the check to mean anything. The bench therefore drives base values that are far from the PC, including wrap-around values, and checks that the target follows the base while the link follows the PC. A stalled registered result is the other case that only appears under back-pressure. The bench holds `out_ready` low for several cycles after acceptance before it consumes the result.

// File: rtl/btu_pkg.sv
package btu_pkg;
  localparam logic [3:0] OP_BR   = 4'h0;
  localparam logic [3:0] OP_CALL = 4'h4;
  localparam logic [3:0] OP_JMP  = 4'hC;

  typedef enum logic [1:0] {
    K_SEQ  = 2'd0,
    K_BR   = 2'd1,
    K_JMP  = 2'd2,
    K_CALL = 2'd3
  } flow_kind_e;
endpackage

// File: rtl/btu_decode.sv
module btu_decode
  import btu_pkg::*;
(
  input  logic [15:0] instr,
  input  logic [2:0]  cc,
  output flow_kind_e  kind,
  output logic        take,
  output logic        use_base,
  output logic        long_off,
  output logic        link
);
  logic [3:0] opc;
  logic       mask_hit;

  assign opc      = instr[15:12];
  assign mask_hit = |(instr[11:9] & cc);

  always_comb begin
    unique case (opc)
      OP_BR:   kind = K_BR;
      OP_JMP:  kind = K_JMP;
      OP_CALL: kind = K_CALL;
      default: kind = K_SEQ;
    endcase
  end

  always_comb begin
    take     = 1'b0;
    use_base = 1'b0;
    long_off = 1'b0;
    link     = 1'b0;
    case (kind)
      K_BR:   take = mask_hit;
      K_JMP: begin
        take     = 1'b1;
        use_base = 1'b1;
      end
      K_CALL: begin
        take     = 1'b1;
        link     = 1'b1;
        long_off = instr[11];
        use_base = ~instr[11];
      end
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/btu_adder.sv
module btu_adder #(
  parameter int XLEN = 16
) (
  input  logic [XLEN-1:0] pc_inc,
  input  logic [15:0]     instr,
  input  logic            long_off,
  output logic [XLEN-1:0] rel_tgt
);
  localparam int SHORT_W = 9;
  localparam int LONG_W  = 11;

  logic [XLEN-1:0] off_short;
  logic [XLEN-1:0] off_long;

  assign off_short = {{(XLEN-SHORT_W){instr[SHORT_W-1]}}, instr[SHORT_W-1:0]};
  assign off_long  = {{(XLEN-LONG_W){instr[LONG_W-1]}}, instr[LONG_W-1:0]};
  assign rel_tgt   = pc_inc + (long_off ? off_long : off_short);
endmodule

// File: rtl/btu_stage.sv
module btu_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      assign s_ready = ~vld_q | m_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          dat_q <= '0;
        end else if (s_ready) begin
          vld_q <= s_valid;
          if (s_valid) dat_q <= s_data;
        end
      end

      assign m_valid = vld_q;
      assign m_data  = dat_q;
    end else begin : g_comb
      assign s_ready = m_ready;
      assign m_valid = s_valid;
      assign m_data  = s_data;
    end
  endgenerate
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit
  import btu_pkg::*;
#(
  parameter int XLEN    = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [15:0]     in_instr,
  input  logic [XLEN-1:0] in_pc_inc,
  input  logic [XLEN-1:0] in_base,
  input  logic [2:0]      in_cc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_next_pc,
  output logic            out_taken,
  output logic            out_link_we,
  output logic [XLEN-1:0] out_link_val
);
  localparam int PAY_W = 2*XLEN + 2;

  flow_kind_e      kind;
  logic            take;
  logic            use_base;
  logic            long_off;
  logic            link;
  logic [XLEN-1:0] rel_tgt;
  logic [XLEN-1:0] nxt;
  logic [XLEN-1:0] lnk;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  btu_decode u_dec (
    .instr    (in_instr),
    .cc       (in_cc),
    .kind     (kind),
    .take     (take),
    .use_base (use_base),
    .long_off (long_off),
    .link     (link)
  );

  btu_adder #(.XLEN(XLEN)) u_add (
    .pc_inc   (in_pc_inc),
    .instr    (in_instr),
    .long_off (long_off),
    .rel_tgt  (rel_tgt)
  );

  // the link value is the incoming PC, taken before any base-register use
  assign lnk    = link ? in_pc_inc : '0;
  assign nxt    = !take ? in_pc_inc : (use_base ? in_base : rel_tgt);
  assign pay_in = {nxt, take, link, lnk};

  btu_stage #(.W(PAY_W), .REG_OUT(REG_OUT)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (pay_in),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (pay_out)
  );

  assign out_next_pc  = pay_out[PAY_W-1 -: XLEN];
  assign out_taken    = pay_out[XLEN+1];
  assign out_link_we  = pay_out[XLEN];
  assign out_link_val = pay_out[XLEN-1:0];
endmodule

// File: rtl/btu_checker.sv
module btu_checker #(
  parameter int XLEN    = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [XLEN-1:0] in_pc_inc,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_next_pc,
  input logic            out_taken,
  input logic            out_link_we,
  input logic [XLEN-1:0] out_link_val
);
  logic [XLEN-1:0] cap_pc;

  generate
    if (REG_OUT) begin : g_cap
      logic [XLEN-1:0] pc_q;
      always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else if (in_valid && in_ready) pc_q <= in_pc_inc;
      end
      assign cap_pc = pc_q;

      AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_next_pc) && $stable(out_taken)
          && $stable(out_link_we) && $stable(out_link_val)); // R8
      AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R8
      AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R9
    end else begin : g_pass
      assign cap_pc = in_pc_inc;
    end
  endgenerate

  AST_LINK_IS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_link_we |-> out_taken && out_link_val == cap_pc); // R5
  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_taken |-> out_next_pc == cap_pc); // R3
  AST_NO_LINK_VAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_link_we |-> out_link_val == '0); // R7
endmodule

bind branch_target_unit btu_checker #(.XLEN(XLEN), .REG_OUT(REG_OUT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_pc_inc    (in_pc_inc),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_next_pc  (out_next_pc),
  .out_taken    (out_taken),
  .out_link_we  (out_link_we),
  .out_link_val (out_link_val)
);

// File: tb/branch_target_unit_bench.sv
module branch_target_unit_bench;
  localparam int XLEN = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [15:0]     in_instr = '0;
  logic [XLEN-1:0] in_pc_inc = '0;
  logic [XLEN-1:0] in_base = '0;
  logic [2:0]      in_cc = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [XLEN-1:0] out_next_pc;
  logic            out_taken;
  logic            out_link_we;
  logic [XLEN-1:0] out_link_val;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  branch_target_unit #(.XLEN(XLEN), .REG_OUT(1'b1)) u_branch_target_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_pc_inc(in_pc_inc), .in_base(in_base), .in_cc(in_cc),
    .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
    .out_taken(out_taken), .out_link_we(out_link_we), .out_link_val(out_link_val)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic logic [XLEN-1:0] sx(input logic [15:0] v, input int bits);
    int s;
    s = int'(v) & ((1 << bits) - 1);
    if (s >= (1 << (bits - 1))) s = s - (1 << bits);
    return XLEN'(s);
  endfunction

  // one transaction; hold = cycles of back-pressure before consuming
  task automatic txn(input string tag, input logic [15:0] ins, input logic [XLEN-1:0] pc,
                     input logic [XLEN-1:0] base, input logic [2:0] cc, input int hold);
    logic [3:0]      opc;
    logic [XLEN-1:0] e_pc, e_lv;
    logic            e_tk, e_lw;
    logic [XLEN*2+1:0] snap;
    opc  = ins[15:12];
    e_pc = pc; e_tk = 1'b0; e_lw = 1'b0; e_lv = '0;
    if (opc == 4'h0) begin
      if ((ins[11:9] & cc) != 3'b000) begin e_tk = 1'b1; e_pc = pc + sx(ins, 9); end
    end else if (opc == 4'hC) begin
      e_tk = 1'b1; e_pc = base;
    end else if (opc == 4'h4) begin
      e_tk = 1'b1; e_lw = 1'b1; e_lv = pc;
      e_pc = ins[11] ? pc + sx(ins, 11) : base;
    end
    @(negedge clk);
    check("R9 ready while empty", 64'(in_ready), 64'd1);
    in_instr = ins; in_pc_inc = pc; in_base = base; in_cc = cc;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_instr = ~ins; in_pc_inc = ~pc; in_base = ~base;
    snap = {out_next_pc, out_taken, out_link_we, out_link_val};
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check("R8 blocked while stalled", 64'(in_ready), 64'd0);
      check("R8 held while stalled", 64'({out_next_pc, out_taken, out_link_we, out_link_val}),
            64'(snap));
    end
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check(tag, 64'({out_next_pc, out_taken, out_link_we, out_link_val}),
          64'({e_pc, e_tk, e_lw, e_lv}));
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    logic [15:0] offs9 [5];
    logic [15:0] offs11 [5];
    logic [XLEN-1:0] pcs [3];
    offs9  = '{16'h000, 16'h001, 16'h0FF, 16'h100, 16'h1FF};
    offs11 = '{16'h000, 16'h001, 16'h3FF, 16'h400, 16'h7FF};
    pcs    = '{16'h3000, 16'hFFFF, 16'h0001};

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", 64'(out_valid), 64'd0);
    check("R1 in_ready after reset", 64'(in_ready), 64'd1);

    // conditional branch: every mask against every condition code
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 8; c++)
        for (int o = 0; o < 5; o++) begin
          logic [15:0] ins;
          ins = {4'h0, 3'(m), offs9[o][8:0]};
          txn(((m & c) != 0) ? "R2 branch taken" : "R3 branch not taken",
              ins, pcs[o % 3], 16'hA5A5, 3'(c), 0);
        end

    // register jump: every base field, base far from PC
    for (int r = 0; r < 8; r++)
      txn("R4 jump to base", {4'hC, 3'(r), 3'(r), 6'h15}, 16'h3000, 16'h8000 + 16'(r * 257), 3'b010, 0);

    // PC-relative call
    for (int o = 0; o < 5; o++)
      for (int p = 0; p < 3; p++)
        txn("R5 relative call", {4'h4, 1'b1, offs11[o][10:0]}, pcs[p], 16'h1234, 3'b001, 0);

    // register call, including through R7
    for (int r = 0; r < 8; r++)
      for (int p = 0; p < 3; p++)
        txn("R6 register call", {4'h4, 1'b0, 2'b11, 3'(r), 6'h2A}, pcs[p], 16'hC0DE ^ 16'(r), 3'b100, 0);
    txn("R6 call through R7 uses old R7", {4'h4, 1'b0, 2'b00, 3'd7, 6'h00}, 16'h3001, 16'h4567, 3'b000, 0);

    // every other opcode
    for (int op = 0; op < 16; op++)
      if (op != 0 && op != 4 && op != 12)
        for (int p = 0; p < 3; p++)
          txn("R7 sequential opcode", {4'(op), 12'hFFF ^ 12'(op * 37)}, pcs[p], 16'h7777, 3'b111, 0);

    // back-pressure
    txn("R8 stalled branch", {4'h0, 3'b111, 9'h180}, 16'h3000, 16'h0, 3'b010, 3);
    txn("R8 stalled call", {4'h4, 1'b1, 11'h005}, 16'h4000, 16'h0, 3'b000, 4);

    report();
  end
endmodule